// File: doc/BRIEF.md
# SPI Data Register Handshake Flag Tracker

This block keeps the handshake state between a host and an SPI shift engine across two single-word holding registers: a transmit register that the host fills and the shifter drains, and a receive register that the shifter fills and the host drains. It records whether each register holds a word, and it raises sticky error flags when either side misuses a register: a second host write to a full transmit register, a shifter demand on an empty one, or a received word arriving while the receive register is still full.

When the shifter wants to receive while the receive register still holds an unread word, the block tells the shifter to hold instead of overwriting. The hold is released by the host's next read. All flags and the hold state are visible at any time in one status word. The serial shifting, chip-select timing and command sequencing live elsewhere; this block only tracks the two registers and their flags.

All flags are registered and change on the clock edge after the strobe that causes them. Reset is synchronous and active high.

Top module: `spi_xfer_flags`

## Requirements
- R1: After reset, the status word, the hold output, the transmit word and the receive word are all zero.
- R2: A host transmit write sets the transmit-full flag (status bit 0) and clears the transmit-underrun flag (status bit 2); when the register was empty, the written word appears on the shifter transmit data output on the next cycle.
- R3: A host transmit write while transmit-full is set and no shifter demand is present sets the sticky transmit-overrun flag (status bit 1) and leaves the held transmit word unchanged.
- R4: A shifter transmit demand clears transmit-full when it is set; when transmit-full is clear and no host write arrives in the same cycle, it sets transmit-underrun and transmit-full stays clear.
- R5: A host write and a shifter demand in the same cycle on a full register leave transmit-full set, raise no overrun, and load the newly written word.
- R6: A received word sets receive-full (status bit 3) and appears on the host receive data output when the register is empty; when receive-full is set and no host read is present, it sets the sticky receive-overrun flag (status bit 4) and the stored word is kept.
- R7: A host receive read clears receive-full; a host read and an arriving word in the same cycle leave receive-full set, hold the new word and raise no overrun.
- R8: A shifter receive request while receive-full is set and no host read is present asserts the hold output (also status bit 5) from the next cycle, which stays asserted until a host read and drops on the cycle after that read; a request while receive-full is clear asserts no hold.
- R9: The two overrun flags stay set until the host error-clear strobe, which clears both and nothing else; a new overrun in the same cycle as the clear strobe wins and leaves its flag set.
- R10: The status word is 8 bits: bit 0 transmit-full, bit 1 transmit-overrun, bit 2 transmit-underrun, bit 3 receive-full, bit 4 receive-overrun, bit 5 hold, bits 7:6 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tx_wr | input | 1 | Host write strobe for the transmit register |
| host_tx_data | input | DATA_W | Word written by the host |
| host_rx_rd | input | 1 | Host read strobe for the receive register |
| host_rx_data | output | DATA_W | Word held in the receive register |
| host_err_clr | input | 1 | Host strobe that clears both overrun flags |
| shf_tx_req | input | 1 | Shifter demand for the next transmit word |
| shf_tx_data | output | DATA_W | Word held in the transmit register |
| shf_rx_valid | input | 1 | Shifter pulse: a received word is present |
| shf_rx_data | input | DATA_W | Word received by the shifter |
| shf_rx_want | input | 1 | Shifter request to start receiving |
| shf_hold | output | 1 | Shifter must wait until the host reads |
| status | output | 8 | Flag word, layout per R10 |

## Verification
A wrong full flag shows on the status word one cycle after the strobe that should have changed it, and a cycle later it shows again as a missing or spurious overrun or underrun when the next strobe of the same kind arrives. A lost sticky bit becomes visible as soon as an idle cycle passes without the clear strobe, and a stuck or missing hold shows on the shifter hold output the cycle after a receive request or a host read. A wrongly loaded data word is seen directly on the transmit or receive data output the cycle after the write or arrival.

// File: rtl/xfer_flag_pkg.sv
package xfer_flag_pkg;

    localparam int STAT_W       = 8;
    localparam int SB_TX_FULL   = 0;
    localparam int SB_TX_OVER   = 1;
    localparam int SB_TX_UNDER  = 2;
    localparam int SB_RX_FULL   = 3;
    localparam int SB_RX_OVER   = 4;
    localparam int SB_HOLD      = 5;

    typedef struct packed {
        logic full;
        logic over;
        logic under;
    } tx_flags_t;

    typedef struct packed {
        logic full;
        logic over;
    } rx_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input tx_flags_t t,
        input rx_flags_t r,
        input logic      hold
    );
        logic [STAT_W-1:0] w;
        w              = '0;
        w[SB_TX_FULL]  = t.full;
        w[SB_TX_OVER]  = t.over;
        w[SB_TX_UNDER] = t.under;
        w[SB_RX_FULL]  = r.full;
        w[SB_RX_OVER]  = r.over;
        w[SB_HOLD]     = hold;
        return w;
    endfunction

endpackage

// File: rtl/xfer_tx_track.sv
module xfer_tx_track
    import xfer_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              req,
    input  logic              clr,
    output tx_flags_t         flags,
    output logic [DATA_W-1:0] word
);

    tx_flags_t         cur_q, nxt;
    logic [DATA_W-1:0] word_q;
    logic              load;
    logic              over_set;

    // A write lands when the slot is empty or is being drained this cycle.
    assign load     = wr && (!cur_q.full || req);
    assign over_set = wr && cur_q.full && !req;

    always_comb begin
        nxt = cur_q;
        if (wr) begin
            nxt.full  = 1'b1;
            nxt.under = 1'b0;
        end else if (req) begin
            if (cur_q.full) begin
                nxt.full = 1'b0;
            end else begin
                nxt.under = 1'b1;
            end
        end
        if (over_set) begin
            nxt.over = 1'b1;
        end else if (clr) begin
            nxt.over = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            word_q <= '0;
        end else begin
            cur_q <= nxt;
            if (load) begin
                word_q <= wdata;
            end
        end
    end

    assign flags = cur_q;
    assign word  = word_q;

endmodule

// File: rtl/xfer_rx_track.sv
module xfer_rx_track
    import xfer_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rd,
    input  logic              clr,
    output rx_flags_t         flags,
    output logic [DATA_W-1:0] word
);

    rx_flags_t         cur_q, nxt;
    logic [DATA_W-1:0] word_q;
    logic              accept;
    logic              over_set;

    // An arrival is stored when the slot is empty or the host drains it now.
    assign accept   = valid && (!cur_q.full || rd);
    assign over_set = valid && cur_q.full && !rd;

    always_comb begin
        nxt = cur_q;
        if (accept) begin
            nxt.full = 1'b1;
        end else if (rd) begin
            nxt.full = 1'b0;
        end
        if (over_set) begin
            nxt.over = 1'b1;
        end else if (clr) begin
            nxt.over = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            word_q <= '0;
        end else begin
            cur_q <= nxt;
            if (accept) begin
                word_q <= rdata;
            end
        end
    end

    assign flags = cur_q;
    assign word  = word_q;

endmodule

// File: rtl/xfer_stall_ctl.sv
module xfer_stall_ctl (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic slot_full,
    input  logic rd,
    output logic hold
);

    logic hold_q;
    logic enter;

    assign enter = want && slot_full && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (rd) begin
            hold_q <= 1'b0;
        end else if (enter) begin
            hold_q <= 1'b1;
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/spi_xfer_flags.sv
module spi_xfer_flags
    import xfer_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_tx_wr,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_rd,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              host_err_clr,
    input  logic              shf_tx_req,
    output logic [DATA_W-1:0] shf_tx_data,
    input  logic              shf_rx_valid,
    input  logic [DATA_W-1:0] shf_rx_data,
    input  logic              shf_rx_want,
    output logic              shf_hold,
    output logic [STAT_W-1:0] status
);

    tx_flags_t tx_f;
    rx_flags_t rx_f;
    logic      hold_w;

    xfer_tx_track #(.DATA_W(DATA_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .wr    (host_tx_wr),
        .wdata (host_tx_data),
        .req   (shf_tx_req),
        .clr   (host_err_clr),
        .flags (tx_f),
        .word  (shf_tx_data)
    );

    xfer_rx_track #(.DATA_W(DATA_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .valid (shf_rx_valid),
        .rdata (shf_rx_data),
        .rd    (host_rx_rd),
        .clr   (host_err_clr),
        .flags (rx_f),
        .word  (host_rx_data)
    );

    xfer_stall_ctl u_stall (
        .clk       (clk),
        .rst       (rst),
        .want      (shf_rx_want),
        .slot_full (rx_f.full),
        .rd        (host_rx_rd),
        .hold      (hold_w)
    );

    assign shf_hold = hold_w;
    assign status   = pack_status(tx_f, rx_f, hold_w);

endmodule

// File: rtl/xfer_flags_chk.sv
module xfer_flags_chk
    import xfer_flag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              host_tx_wr,
    input logic              host_rx_rd,
    input logic [DATA_W-1:0] host_rx_data,
    input logic              host_err_clr,
    input logic              shf_tx_req,
    input logic [DATA_W-1:0] shf_tx_data,
    input logic              shf_rx_valid,
    input logic              shf_rx_want,
    input logic              shf_hold,
    input logic [STAT_W-1:0] status
);

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (status == '0 && !shf_hold));

    // R2
    tx_write_full_chk: assert property (@(posedge clk) disable iff (rst)
        host_tx_wr |=> (status[SB_TX_FULL] && !status[SB_TX_UNDER]));

    // R3
    tx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (host_tx_wr && status[SB_TX_FULL] && !shf_tx_req)
        |=> (status[SB_TX_OVER] && $stable(shf_tx_data)));

    // R4
    tx_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        (shf_tx_req && !status[SB_TX_FULL] && !host_tx_wr)
        |=> (status[SB_TX_UNDER] && !status[SB_TX_FULL]));

    // R6
    rx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (shf_rx_valid && status[SB_RX_FULL] && !host_rx_rd)
        |=> (status[SB_RX_OVER] && $stable(host_rx_data)));

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        host_rx_rd |=> !shf_hold);

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (shf_hold && !host_rx_rd) |=> shf_hold);

    // R8
    hold_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (shf_rx_want && status[SB_RX_FULL] && !host_rx_rd) |=> shf_hold);

    // R9
    tx_over_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[SB_TX_OVER] && !host_err_clr) |=> status[SB_TX_OVER]);

    // R9
    rx_over_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[SB_RX_OVER] && !host_err_clr) |=> status[SB_RX_OVER]);

    // R10
    status_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (status[7:6] == 2'b00) && (status[SB_HOLD] == shf_hold));

endmodule

bind spi_xfer_flags xfer_flags_chk #(.DATA_W(DATA_W)) u_flags_chk (
    .clk          (clk),
    .rst          (rst),
    .host_tx_wr   (host_tx_wr),
    .host_rx_rd   (host_rx_rd),
    .host_rx_data (host_rx_data),
    .host_err_clr (host_err_clr),
    .shf_tx_req   (shf_tx_req),
    .shf_tx_data  (shf_tx_data),
    .shf_rx_valid (shf_rx_valid),
    .shf_rx_want  (shf_rx_want),
    .shf_hold     (shf_hold),
    .status       (status)
);

// File: tb/tb_spi_xfer_flags.sv
module tb_spi_xfer_flags;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_tx_wr = 1'b0;
    logic [DW-1:0] host_tx_data = '0;
    logic          host_rx_rd = 1'b0;
    logic [DW-1:0] host_rx_data;
    logic          host_err_clr = 1'b0;
    logic          shf_tx_req = 1'b0;
    logic [DW-1:0] shf_tx_data;
    logic          shf_rx_valid = 1'b0;
    logic [DW-1:0] shf_rx_data = '0;
    logic          shf_rx_want = 1'b0;
    logic          shf_hold;
    logic [7:0]    status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    spi_xfer_flags #(.DATA_W(DW)) dut (
        .clk          (clk),
        .rst          (rst),
        .host_tx_wr   (host_tx_wr),
        .host_tx_data (host_tx_data),
        .host_rx_rd   (host_rx_rd),
        .host_rx_data (host_rx_data),
        .host_err_clr (host_err_clr),
        .shf_tx_req   (shf_tx_req),
        .shf_tx_data  (shf_tx_data),
        .shf_rx_valid (shf_rx_valid),
        .shf_rx_data  (shf_rx_data),
        .shf_rx_want  (shf_rx_want),
        .shf_hold     (shf_hold),
        .status       (status)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h, want %h", tag, act, exp);
        end
    endtask

    // Inputs are driven at the falling edge; one rising edge later, results are sampled.
    task automatic tick();
        @(negedge clk);
        host_tx_wr   = 1'b0;
        host_rx_rd   = 1'b0;
        host_err_clr = 1'b0;
        shf_tx_req   = 1'b0;
        shf_rx_valid = 1'b0;
        shf_rx_want  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        chk("R1 status", {56'd0, status}, 64'h00);
        chk("R1 hold", {63'd0, shf_hold}, 64'd0);
        chk("R1 tx word", shf_tx_data, '0);
        chk("R1 rx word", host_rx_data, '0);
    endtask

    task automatic t_tx();
        host_tx_wr = 1'b1; host_tx_data = 64'hA5A5_0000_1111_2222;
        tick();
        chk("R2 R10 full bit0", {56'd0, status}, 64'h01);
        chk("R2 tx word", shf_tx_data, 64'hA5A5_0000_1111_2222);
        host_tx_wr = 1'b1; host_tx_data = 64'hBBBB_BBBB_BBBB_BBBB;
        tick();
        chk("R3 overrun bit1", {56'd0, status}, 64'h03);
        chk("R3 word kept", shf_tx_data, 64'hA5A5_0000_1111_2222);
        tick();
        chk("R9 tx over sticky", {56'd0, status}, 64'h03);
        shf_tx_req = 1'b1;
        tick();
        chk("R4 demand clears full", {56'd0, status}, 64'h02);
        shf_tx_req = 1'b1;
        tick();
        chk("R4 underrun bit2", {56'd0, status}, 64'h06);
        host_tx_wr = 1'b1; host_tx_data = 64'h0123_4567_89AB_CDEF;
        tick();
        chk("R2 write clears underrun", {56'd0, status}, 64'h03);
        chk("R2 word after empty", shf_tx_data, 64'h0123_4567_89AB_CDEF);
        host_err_clr = 1'b1;
        tick();
        chk("R9 clear strobe", {56'd0, status}, 64'h01);
        host_tx_wr = 1'b1; shf_tx_req = 1'b1; host_tx_data = 64'hDDDD_0000_DDDD_0001;
        tick();
        chk("R5 race status", {56'd0, status}, 64'h01);
        chk("R5 race word", shf_tx_data, 64'hDDDD_0000_DDDD_0001);
    endtask

    task automatic t_rx();
        shf_rx_valid = 1'b1; shf_rx_data = 64'hEEEE_1234_EEEE_5678;
        tick();
        chk("R6 R10 rx full bit3", {56'd0, status}, 64'h09);
        chk("R6 rx word", host_rx_data, 64'hEEEE_1234_EEEE_5678);
        shf_rx_valid = 1'b1; shf_rx_data = 64'hFFFF_FFFF_0000_0000;
        tick();
        chk("R6 rx overrun bit4", {56'd0, status}, 64'h19);
        chk("R6 rx word kept", host_rx_data, 64'hEEEE_1234_EEEE_5678);
        host_rx_rd = 1'b1;
        tick();
        chk("R7 read clears full", {56'd0, status}, 64'h11);
        host_err_clr = 1'b1;
        tick();
        chk("R9 clear rx over", {56'd0, status}, 64'h01);
        shf_rx_valid = 1'b1; shf_rx_data = 64'h1111_2222_3333_4444;
        tick();
        host_rx_rd = 1'b1; shf_rx_valid = 1'b1; shf_rx_data = 64'h5555_6666_7777_8888;
        tick();
        chk("R7 read race status", {56'd0, status}, 64'h09);
        chk("R7 read race word", host_rx_data, 64'h5555_6666_7777_8888);
    endtask

    task automatic t_stall();
        shf_rx_want = 1'b1;
        tick();
        chk("R8 hold entered", {63'd0, shf_hold}, 64'd1);
        chk("R8 R10 hold bit5", {56'd0, status}, 64'h29);
        for (int i = 0; i < 3; i++) tick();
        chk("R8 hold kept", {63'd0, shf_hold}, 64'd1);
        host_rx_rd = 1'b1;
        tick();
        chk("R8 hold released", {63'd0, shf_hold}, 64'd0);
        chk("R8 status after read", {56'd0, status}, 64'h01);
        shf_rx_want = 1'b1;
        tick();
        chk("R8 no hold when empty", {63'd0, shf_hold}, 64'd0);
    endtask

    task automatic t_clr_race();
        host_tx_wr = 1'b1; host_err_clr = 1'b1; host_tx_data = 64'h9999_9999_9999_9999;
        tick();
        chk("R9 set beats clear", {56'd0, status}, 64'h03);
        chk("R3 word kept in race", shf_tx_data, 64'hDDDD_0000_DDDD_0001);
        host_err_clr = 1'b1;
        tick();
        chk("R9 clear leaves full", {56'd0, status}, 64'h01);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tx();
        t_rx();
        t_stall();
        t_clr_race();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule